// File: doc/BRIEF.md
# Programmable Symbol Clock Generator

This block derives every timing strobe of a digital modulator's baseband path from one master clock. A programmable divider produces a one-cycle sample-enable pulse at the filter sampling rate. A divide-by-two of that rate gives a square bit clock, and every fourth sample pulse is marked as a symbol boundary. A second, independent divider produces an auxiliary clock for external use. When the main clock enable is low, the auxiliary clock keeps running and everything else stands still.

In external-clock mode the divider first runs freely. After it is armed, it waits for a rising edge on an external transmit bit clock. It then moves its own bit clock so that a falling edge lands a fixed number of master cycles after that edge, and this offset follows the programmed divisor. A small state machine handles the arming and locking. ST_FREE is internal timing. ST_HUNT waits for an external edge. ST_WAIT holds while the resync control is high. ST_DELAY counts the offset. ST_LOCKED is free-running after alignment.

The transitions are:
- ext_mode low: any state goes to ST_FREE.
- resync high: any state goes to ST_WAIT.
- clock enable rising: any state goes to ST_HUNT.
- From ST_FREE: go to ST_HUNT once ext_mode is high.
- From ST_WAIT: go to ST_HUNT when resync returns low.
- From ST_HUNT: go to ST_DELAY on a detected external edge.
- From ST_DELAY: go to ST_LOCKED when the offset counter expires.

Top module: `symclk_gen`

## Requirements
- R1: For a sampling divisor n (4..255) whose low four bits are not all zero, samp_en is a single-cycle pulse every n+1 master cycles. After reset release, the first pulse is visible after master edge n+1.
- R2: For a sampling divisor whose low four bits are all zero, samp_en is a single-cycle pulse every n+17 master cycles.
- R3: bit_clk changes state only together with a samp_en pulse. It is high for one sampling period and low for the next, so its period is twice the sampling period. It is 0 after reset and first rises with the first samp_en.
- R4: sym_strobe is high together with every fourth samp_en pulse. After reset the first strobe comes with the fourth pulse.
- R5: For an auxiliary divisor m from 2 to 15, aux_clk has a period of m+1 master cycles, high for 2 and low for m-1. It is 1 out of reset, low after edge 2 and high again after edge m+1.
- R6: An auxiliary divisor of 0 or 1 holds aux_clk constantly high.
- R7: While clk_en is low, samp_en and sym_strobe stay 0, bit_clk holds its value and aux_clk keeps toggling.
- R8: In external mode (ext_mode = 1), once armed, let E be the first master edge that samples tclk_in high after a rising transition. bit_clk is driven low and samp_en pulses at edge E+n+4. Later samp_en pulses follow every sampling period from there, with bit_clk rising at the first of them.
- R9: Arming happens on entry to external mode, on resync going high and then low, or on clk_en rising. tclk_in edges seen while resync is high, or after lock without a new arming, do not move the bit clock.
- R10: When the lock edge coincides with a regular divider wrap, only one samp_en pulse is produced, sym_strobe is 0 on that edge, and the symbol count restarts so that the next sym_strobe comes with the fourth pulse after the lock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Gate for all generated timing except the auxiliary clock |
| tclk_in | input | 1 | External transmit bit clock, asynchronous |
| samp_div | input | 8 | Sampling divisor n |
| aux_div | input | 4 | Auxiliary divisor m |
| ext_mode | input | 1 | 1 = lock the bit clock to tclk_in |
| resync | input | 1 | High-then-low re-arms locking |
| samp_en | output | 1 | One-cycle pulse per sampling period |
| bit_clk | output | 1 | Square bit clock at half the sampling rate |
| aux_clk | output | 1 | Auxiliary divided clock |
| sym_strobe | output | 1 | Pulse with every fourth sample pulse |

## Verification
The forced alignment at the end of the offset count can land on the same master edge as the free-running divider's own wrap. In that case the two compete for samp_en, bit_clk and the symbol counter. The bench provokes this by first observing a sample pulse on the running grid. It then raises tclk_in at the one cycle that puts the lock edge exactly two sampling periods later. It judges the result by a single pulse with bit_clk low and no strobe on that edge, and by the next strobe arriving four periods after it.

// File: rtl/symclk_pkg.sv
package symclk_pkg;

    typedef enum logic [2:0] {
        ST_FREE,
        ST_HUNT,
        ST_WAIT,
        ST_DELAY,
        ST_LOCKED
    } lock_state_t;

endpackage

// File: rtl/symclk_tclk_sync.sv
module symclk_tclk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tclk_in,
    output logic tclk_rise
);

    logic [STAGES-1:0] stage_q;
    logic              last_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= 1'b0;
                else        stage_q[g] <= tclk_in;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= 1'b0;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= stage_q[STAGES-1];
    end

    assign tclk_rise = stage_q[STAGES-1] & ~last_q;

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tclk_rise |=> !tclk_rise); // R8

endmodule

// File: rtl/symclk_lock_fsm.sv
module symclk_lock_fsm
    import symclk_pkg::*;
#(
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  logic             ext_mode,
    input  logic             resync,
    input  logic             tclk_rise,
    input  logic [DIV_W-1:0] samp_div,
    output logic             lock_now
);

    localparam int OFF_W = DIV_W + 1;

    lock_state_t      state, state_nx;
    logic [OFF_W-1:0] off_cnt;
    logic [OFF_W-1:0] off_load;
    logic             en_q;
    logic             arm;

    assign arm      = clk_en & ~en_q;
    assign off_load = OFF_W'(samp_div) + OFF_W'(3) - OFF_W'(SYNC_STAGES);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= clk_en;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      state <= ST_FREE;
        else if (clk_en) state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        if (!ext_mode) begin
            state_nx = ST_FREE;
        end else if (resync) begin
            state_nx = ST_WAIT;
        end else if (arm) begin
            state_nx = ST_HUNT;
        end else begin
            unique case (state)
                ST_FREE:   state_nx = ST_HUNT;
                ST_WAIT:   state_nx = ST_HUNT;
                ST_HUNT:   if (tclk_rise) state_nx = ST_DELAY;
                ST_DELAY:  if (off_cnt == '0) state_nx = ST_LOCKED;
                ST_LOCKED: state_nx = ST_LOCKED;
                default:   state_nx = ST_FREE;
            endcase
        end
    end

    // outputs
    always_comb begin
        lock_now = clk_en && (state == ST_DELAY) && (state_nx == ST_LOCKED);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_cnt <= '0;
        end else if (clk_en) begin
            if (state == ST_HUNT && state_nx == ST_DELAY)
                off_cnt <= off_load;
            else if (state == ST_DELAY && off_cnt != '0)
                off_cnt <= off_cnt - 1'b1;
        end
    end

    AST_LOCK_IN_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        lock_now |-> ext_mode); // R8

    AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && resync && ext_mode && clk_en) |=> (state == ST_WAIT)); // R9

    AST_DELAY_FROM_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_DELAY) |-> ($past(state == ST_HUNT) && $past(tclk_rise))); // R9

endmodule

// File: rtl/symclk_samp_div.sv
module symclk_samp_div #(
    parameter int DIV_W       = 8,
    parameter int ANOM_BITS   = 4,
    parameter int SYM_SAMPLES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  logic [DIV_W-1:0] samp_div,
    input  logic             lock_now,
    output logic             samp_en,
    output logic             bit_clk,
    output logic             sym_strobe
);

    localparam int CNT_W = DIV_W + 1;
    localparam int PH_W  = (SYM_SAMPLES > 2) ? $clog2(SYM_SAMPLES) : 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] wrap_at;
    logic [PH_W-1:0]  phase;
    logic             anom;
    logic             wrap;

    assign anom    = (samp_div[ANOM_BITS-1:0] == '0);
    assign wrap_at = CNT_W'(samp_div) + (anom ? CNT_W'(1 << ANOM_BITS) : '0);
    assign wrap    = (cnt >= wrap_at);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt        <= '0;
            phase      <= '0;
            samp_en    <= 1'b0;
            bit_clk    <= 1'b0;
            sym_strobe <= 1'b0;
        end else if (!clk_en) begin
            samp_en    <= 1'b0;
            sym_strobe <= 1'b0;
        end else if (lock_now) begin
            cnt        <= '0;
            phase      <= '0;
            samp_en    <= 1'b1;
            bit_clk    <= 1'b0;
            sym_strobe <= 1'b0;
        end else if (wrap) begin
            cnt        <= '0;
            samp_en    <= 1'b1;
            bit_clk    <= ~bit_clk;
            sym_strobe <= (phase == PH_W'(SYM_SAMPLES - 1));
            phase      <= (phase == PH_W'(SYM_SAMPLES - 1)) ? '0 : phase + 1'b1;
        end else begin
            cnt        <= cnt + 1'b1;
            samp_en    <= 1'b0;
            sym_strobe <= 1'b0;
        end
    end

    AST_BITCLK_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bit_clk) |-> samp_en); // R3

    AST_STROBE_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        sym_strobe |-> samp_en); // R4

    AST_GATED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> (!samp_en && !sym_strobe && $stable(bit_clk))); // R7

    AST_LOCK_ALIGNS: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_now && clk_en) |=> (samp_en && !bit_clk && !sym_strobe)); // R10

endmodule

// File: rtl/symclk_aux_div.sv
module symclk_aux_div #(
    parameter int AUX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AUX_W-1:0] aux_div,
    output logic             aux_clk
);

    logic [AUX_W-1:0] acnt;
    logic             parked;

    assign parked = (aux_div < AUX_W'(2));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acnt    <= '0;
            aux_clk <= 1'b1;
        end else if (parked || acnt >= aux_div) begin
            acnt    <= '0;
            aux_clk <= 1'b1;
        end else begin
            acnt    <= acnt + 1'b1;
            aux_clk <= (acnt == '0);
        end
    end

    AST_AUX_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        parked |=> aux_clk); // R6

    AST_AUX_HIGH_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(aux_clk) |=> aux_clk); // R5

endmodule

// File: rtl/symclk_gen.sv
module symclk_gen #(
    parameter int DIV_W       = 8,
    parameter int AUX_W       = 4,
    parameter int SYNC_STAGES = 2,
    parameter int SYM_SAMPLES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  logic             tclk_in,
    input  logic [DIV_W-1:0] samp_div,
    input  logic [AUX_W-1:0] aux_div,
    input  logic             ext_mode,
    input  logic             resync,
    output logic             samp_en,
    output logic             bit_clk,
    output logic             aux_clk,
    output logic             sym_strobe
);

    logic tclk_rise;
    logic lock_now;

    symclk_tclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .tclk_in   (tclk_in),
        .tclk_rise (tclk_rise)
    );

    symclk_lock_fsm #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_en    (clk_en),
        .ext_mode  (ext_mode),
        .resync    (resync),
        .tclk_rise (tclk_rise),
        .samp_div  (samp_div),
        .lock_now  (lock_now)
    );

    symclk_samp_div #(.DIV_W(DIV_W), .ANOM_BITS(4), .SYM_SAMPLES(SYM_SAMPLES)) u_samp (
        .clk        (clk),
        .rst_n      (rst_n),
        .clk_en     (clk_en),
        .samp_div   (samp_div),
        .lock_now   (lock_now),
        .samp_en    (samp_en),
        .bit_clk    (bit_clk),
        .sym_strobe (sym_strobe)
    );

    symclk_aux_div #(.AUX_W(AUX_W)) u_aux (
        .clk     (clk),
        .rst_n   (rst_n),
        .aux_div (aux_div),
        .aux_clk (aux_clk)
    );

endmodule

// File: tb/symclk_gen_bench.sv
module symclk_gen_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clk_en = 1'b1;
    logic       tclk_in = 1'b0;
    logic [7:0] samp_div = 8'd10;
    logic [3:0] aux_div = 4'd5;
    logic       ext_mode = 1'b0;
    logic       resync = 1'b0;
    logic       samp_en, bit_clk, aux_clk, sym_strobe;

    int cyc = 0;
    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    symclk_gen u_symclk_gen (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .tclk_in(tclk_in),
        .samp_div(samp_div), .aux_div(aux_div), .ext_mode(ext_mode),
        .resync(resync), .samp_en(samp_en), .bit_clk(bit_clk),
        .aux_clk(aux_clk), .sym_strobe(sym_strobe)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic wait_until(input int e);
        while (cyc < e) @(negedge clk);
    endtask

    task automatic wait_n(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic next_pulse(output int t);
        @(negedge clk);
        while (samp_en !== 1'b1) @(negedge clk);
        t = cyc;
    endtask

    // R1 R3 R4 R5 reset state and free-running timing, n=10, m=5
    task automatic t_reset_and_free();
        chk("R3 reset bit_clk", int'(bit_clk), 0);
        chk("R1 reset samp_en", int'(samp_en), 0);
        chk("R4 reset sym_strobe", int'(sym_strobe), 0);
        chk("R5 reset aux_clk", int'(aux_clk), 1);
        @(negedge clk); rst_n = 1'b1;
        wait_until(2);  chk("R5 aux low after edge 2", int'(aux_clk), 0);
        wait_until(6);  chk("R5 aux high after edge m+1", int'(aux_clk), 1);
        wait_until(7);  chk("R5 aux high second cycle", int'(aux_clk), 1);
        wait_until(8);  chk("R5 aux low again", int'(aux_clk), 0);
        wait_until(10); chk("R1 no pulse before n+1", int'(samp_en), 0);
        wait_until(11); chk("R1 first pulse", int'(samp_en), 1);
                        chk("R3 first rise", int'(bit_clk), 1);
        wait_until(12); chk("R1 pulse one cycle", int'(samp_en), 0);
                        chk("R5 aux period 6", int'(aux_clk), 1);
        wait_until(22); chk("R3 fall after two periods", int'(bit_clk), 0);
                        chk("R1 second pulse", int'(samp_en), 1);
        wait_until(33); chk("R4 no strobe on third", int'(sym_strobe), 0);
        wait_until(44); chk("R4 strobe on fourth", int'(sym_strobe), 1);
    endtask

    // R1 R2 period measurement for several divisors
    task automatic t_periods();
        int t0, t1;
        samp_div = 8'd16;
        next_pulse(t0); next_pulse(t0); next_pulse(t1);
        chk("R2 n=16 period", t1 - t0, 33);
        samp_div = 8'd32;
        next_pulse(t0); next_pulse(t0); next_pulse(t1);
        chk("R2 n=32 period", t1 - t0, 49);
        samp_div = 8'd17;
        next_pulse(t0); next_pulse(t0); next_pulse(t1);
        chk("R1 n=17 period", t1 - t0, 18);
        samp_div = 8'd4;
        next_pulse(t0); next_pulse(t0); next_pulse(t1);
        chk("R1 n=4 period", t1 - t0, 5);
        samp_div = 8'd10;
        next_pulse(t0);
    endtask

    // R5 R6 auxiliary divisor settings
    task automatic t_aux();
        int highs;
        aux_div = 4'd1; wait_n(3);
        highs = 0;
        for (int i = 0; i < 20; i++) begin @(negedge clk); highs += int'(aux_clk); end
        chk("R6 m=1 held high", highs, 20);
        aux_div = 4'd0; wait_n(3);
        highs = 0;
        for (int i = 0; i < 20; i++) begin @(negedge clk); highs += int'(aux_clk); end
        chk("R6 m=0 held high", highs, 20);
        aux_div = 4'd15;
        while (aux_clk !== 1'b0) @(negedge clk);
        while (aux_clk !== 1'b1) @(negedge clk);
        highs = 0;
        for (int i = 0; i < 32; i++) begin @(negedge clk); highs += int'(aux_clk); end
        chk("R5 m=15 two highs per 16", highs, 4);
        aux_div = 4'd5;
    endtask

    // R7 clock enable low freezes everything but aux
    task automatic t_gate();
        int bad_pulse, bad_clk, aux_edges;
        logic held, aux_last;
        clk_en = 1'b0;
        @(negedge clk);
        held = bit_clk; aux_last = aux_clk;
        bad_pulse = 0; bad_clk = 0; aux_edges = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (samp_en !== 1'b0 || sym_strobe !== 1'b0) bad_pulse++;
            if (bit_clk !== held) bad_clk++;
            if (aux_clk !== aux_last) aux_edges++;
            aux_last = aux_clk;
        end
        chk("R7 no pulses while gated", bad_pulse, 0);
        chk("R7 bit_clk held while gated", bad_clk, 0);
        chk("R7 aux keeps toggling", int'(aux_edges > 8), 1);
        clk_en = 1'b1;
        wait_n(2);
    endtask

    // R8 R9 lock on entry to external mode, ignored edge while locked
    task automatic t_lock();
        int k0, lk;
        ext_mode = 1'b1;
        wait_n(4);
        tclk_in = 1'b1; k0 = cyc + 1;
        wait_until(k0 + 4); tclk_in = 1'b0;
        lk = k0 + 14;
        wait_until(lk);      chk("R8 lock pulse", int'(samp_en), 1);
                             chk("R8 lock bit_clk low", int'(bit_clk), 0);
        wait_until(lk + 1);  chk("R8 single lock pulse", int'(samp_en), 0);
        wait_until(lk + 11); chk("R8 pulse after lock", int'(samp_en), 1);
                             chk("R8 rise after lock", int'(bit_clk), 1);
        wait_until(lk + 22); chk("R8 fall on grid", int'(bit_clk), 0);
        wait_until(lk + 47); tclk_in = 1'b1;
        wait_until(lk + 52); tclk_in = 1'b0;
        wait_until(lk + 55); chk("R9 locked edge ignored pulse", int'(samp_en), 1);
                             chk("R9 locked edge ignored level", int'(bit_clk), 1);
        wait_until(lk + 66); chk("R9 locked edge ignored fall", int'(samp_en), 1);
                             chk("R9 locked grid bit_clk", int'(bit_clk), 0);
    endtask

    // R8 R9 re-arm through resync, edge during resync high ignored, n=16
    task automatic t_resync();
        int k, lk;
        samp_div = 8'd16;
        resync = 1'b1; wait_n(2);
        tclk_in = 1'b1; wait_n(4);
        tclk_in = 1'b0; wait_n(3);
        resync = 1'b0; wait_n(3);
        tclk_in = 1'b1; k = cyc + 1;
        wait_until(k + 4); tclk_in = 1'b0;
        lk = k + 20;
        wait_until(lk);      chk("R8 n=16 offset pulse", int'(samp_en), 1);
                             chk("R9 resync relock bit_clk", int'(bit_clk), 0);
        wait_until(lk + 1);  chk("R9 single pulse", int'(samp_en), 0);
        wait_until(lk + 33); chk("R2 n=16 after lock", int'(samp_en), 1);
                             chk("R8 rise after relock", int'(bit_clk), 1);
        samp_div = 8'd10;
        wait_n(40);
    endtask

    // R9 re-arm through clock enable rising
    task automatic t_enable_arm();
        int k;
        clk_en = 1'b0; wait_n(5);
        clk_en = 1'b1; wait_n(3);
        tclk_in = 1'b1; k = cyc + 1;
        wait_until(k + 4); tclk_in = 1'b0;
        wait_until(k + 14); chk("R9 enable arm lock pulse", int'(samp_en), 1);
                            chk("R9 enable arm bit_clk", int'(bit_clk), 0);
        wait_until(k + 25); chk("R9 enable arm next pulse", int'(samp_en), 1);
    endtask

    // R10 lock edge coincides with a regular wrap
    task automatic t_coincide();
        int g, lk;
        resync = 1'b1; wait_n(1);
        resync = 1'b0; wait_n(3);
        next_pulse(g);
        wait_until(g + 7); tclk_in = 1'b1;
        wait_until(g + 12); tclk_in = 1'b0;
        lk = g + 22;
        wait_until(lk);      chk("R10 coincident pulse", int'(samp_en), 1);
                             chk("R10 coincident bit_clk low", int'(bit_clk), 0);
                             chk("R10 no strobe on lock", int'(sym_strobe), 0);
        wait_until(lk + 1);  chk("R10 no double pulse", int'(samp_en), 0);
        wait_until(lk + 11); chk("R10 next pulse", int'(samp_en), 1);
        wait_until(lk + 33); chk("R10 no strobe third", int'(sym_strobe), 0);
        wait_until(lk + 44); chk("R10 strobe fourth after lock", int'(sym_strobe), 1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait_n(3);
        t_reset_and_free();
        t_periods();
        t_aux();
        t_gate();
        t_lock();
        t_resync();
        t_enable_arm();
        t_coincide();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule